// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block keeps an asynchronous DRAM of 4096 rows refreshed and brings it out of power-on. It counts out a long power-up wait first. Then it runs a fixed number of warm-up refresh cycles on its own, without asking anyone, and raises a ready flag. From then on it builds up refresh debt at a steady rate so that every row is refreshed within the retention window. It asks the main memory controller for a slot for each refresh it owes. When the controller grants a slot, or when the debt has reached its limit, the block drives the RAS, CAS and WE strobes for one refresh cycle.

A build-time parameter selects one of two refresh styles. In the first style, CAS falls before RAS and the device supplies the row itself. In the second style, only RAS is strobed and the block presents the row from its own counter. All timing limits are given in nanoseconds, together with the clock period, and are rounded up to whole clock counts. WE is held high through every cycle, so a CAS-first refresh can never be taken for the device's test-mode entry.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, ras_n, cas_n and we_n are 1, ready, ref_req and ref_urgent are 0, and row_addr is 0.
- R2: After reset is released, no strobe goes low during the first ceil(POWERUP_NS/CLK_NS) clock cycles.
- R3: After the power-up wait, exactly WARMUP_REFS (8) refresh cycles run without any handshake. ready rises on the cycle after the last of them ends and stays high until reset.
- R4: In the CAS-first style (RAS_ONLY=0), cas_n goes low ceil(T_CSR_NS/CLK_NS) cycles before ras_n falls. Both strobes then stay low together, and rise together.
- R5: we_n is 1 on every cycle, in both styles.
- R6: In the RAS-only style (RAS_ONLY=1), cas_n stays 1. row_addr is presented ceil(T_CSR_NS/CLK_NS) cycles before ras_n falls and holds still while ras_n is low.
- R7: In the RAS-only style, row_addr advances by one after each refresh and wraps from ROWS-1 (4095) to 0. In the CAS-first style, row_addr stays 0.
- R8: ras_n is low for exactly ceil(T_RAS_NS/CLK_NS) cycles in each refresh. It is then high for at least max(ceil(T_RP_NS/CLK_NS), ceil(T_RC_NS/CLK_NS) - ceil(T_RAS_NS/CLK_NS)) cycles, plus one idle cycle, before the next refresh may begin.
- R9: Once ready is high, one refresh is owed every floor(WINDOW_NS/ROWS/CLK_NS) cycles. The first one appears on ref_req exactly that many cycles after ready rises.
- R10: ref_req is 1 exactly when ready is high, no refresh is in progress, and at least one refresh is owed. If ref_gnt is 1 in such a cycle, the refresh starts on the next cycle and ref_req drops.
- R11: The owed count saturates at MAX_PENDING (8). ref_urgent is 1 while the count is at that limit. In that state a refresh starts on the next cycle even when ref_gnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_gnt | input | 1 | Slot grant from the main controller |
| ref_req | output | 1 | Refresh slot request |
| ref_urgent | output | 1 | Owed refreshes at limit; the next one goes ahead without grant |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| row_addr | output | ROW_W (12) | Row to refresh in RAS-only style |
| ready | output | 1 | Start-up sequence complete |

## Verification
Faults in the phase or counter state would show up as a strobe edge in the wrong cycle. The bench's per-cycle model catches that in the very cycle it happens. A wrong owed count shows up on ref_req or ref_urgent within one refresh interval. A wrong start-up counter moves the rise of ready away from its single legal cycle. A row counter that steps or wraps wrongly differs from the model on the first RAS-only refresh after the fault. That refresh is at most one interval away, because the bench compares row_addr on every clock.

// File: rtl/dram_ref_pkg.sv
// Shared types and timing helpers for the refresh scheduler.
// Assumes all timing values are positive integers in nanoseconds.
package dram_ref_pkg;

    typedef enum logic [1:0] {INIT_PWR, INIT_WARM, INIT_RUN} init_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_ACT, SQ_PRE} seq_e;

    // Minimum time to whole clocks, rounded up, never below one.
    function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    // Maximum spacing to whole clocks, rounded down, never below one.
    function automatic int unsigned cyc_floor(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = ns / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_tick_gen.sv
// Interval timer: pulses tick once every PERIOD enabled cycles.
// Assumes en stays high once raised (it follows the ready state).
module ref_tick_gen #(
    parameter int unsigned PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(PERIOD - 1));

    // Count enabled cycles, restart on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (en) cnt <= tick ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/ref_pending.sv
// Owed-refresh counter, saturating at LIMIT; flags the limit as urgent.
// Assumes dec is only raised while the count is non-zero.
module ref_pending #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic urgent
);
    localparam int unsigned PW = $clog2(LIMIT + 1);

    logic [PW-1:0] cnt;

    assign nonzero = (cnt != '0);
    assign urgent  = (cnt == PW'(LIMIT));

    // Add owed refreshes, remove started ones, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (inc && !dec)    cnt <= urgent ? cnt : cnt + PW'(1);
        else if (dec && !inc)    cnt <= cnt - PW'(1);
    end
endmodule

// File: rtl/ref_strobe_seq.sv
// Strobe sequencer for one refresh: setup, RAS active, precharge.
// RAS_ONLY selects the style: CAS-first (0) or row-addressed RAS-only (1).
// Assumes start is only raised while idle is high.
module ref_strobe_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned ACT_CYC   = 6,
    parameter int unsigned PRE_CYC   = 5,
    parameter int unsigned ROWS      = 4096,
    parameter bit          RAS_ONLY  = 1'b0,
    localparam int unsigned ROW_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             idle,
    output logic             done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr
);
    localparam int unsigned LONGEST = max2(max2(SETUP_CYC, ACT_CYC), PRE_CYC);
    localparam int unsigned CW      = $clog2(LONGEST + 1);

    seq_e          st;
    logic [CW-1:0] cnt;
    logic          last;
    logic          act_end;

    // Flag the final cycle of the current phase.
    always_comb begin
        case (st)
            SQ_SETUP: last = (cnt == CW'(SETUP_CYC - 1));
            SQ_ACT:   last = (cnt == CW'(ACT_CYC - 1));
            SQ_PRE:   last = (cnt == CW'(PRE_CYC - 1));
            default:  last = 1'b0;
        endcase
    end

    // Step through the phases of one refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else if (st == SQ_IDLE) begin
            if (start) st <= SQ_SETUP;
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
            case (st)
                SQ_SETUP: st <= SQ_ACT;
                SQ_ACT:   st <= SQ_PRE;
                default:  st <= SQ_IDLE;
            endcase
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign idle    = (st == SQ_IDLE);
    assign done    = (st == SQ_PRE) && last;
    assign act_end = (st == SQ_ACT) && last;
    assign ras_n   = (st != SQ_ACT);
    assign we_n    = 1'b1;

    generate
        if (RAS_ONLY) begin : g_row_addr
            logic [ROW_W-1:0] row_q;
            // Advance the row after each active phase, wrap at ROWS-1.
            always_ff @(posedge clk) begin
                if (!rst_n)       row_q <= '0;
                else if (act_end) row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + ROW_W'(1);
            end
            assign row_addr = row_q;
            assign cas_n    = 1'b1;
        end else begin : g_cas_first
            assign row_addr = '0;
            assign cas_n    = !((st == SQ_SETUP) || (st == SQ_ACT));
        end
    endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the refresh scheduler: power-up wait, warm-up refreshes, then
// rate-driven refresh requests with a grant handshake and a forced slot
// when the owed count reaches its limit.
// Assumes the controller releases the DRAM strobes in the cycle after a
// grant or while ref_urgent is high.
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned POWERUP_NS  = 200000,
    parameter int unsigned WARMUP_REFS = 8,
    parameter int unsigned ROWS        = 4096,
    parameter int unsigned WINDOW_NS   = 64000000,
    parameter int unsigned T_RAS_NS    = 60,
    parameter int unsigned T_RP_NS     = 40,
    parameter int unsigned T_RC_NS     = 110,
    parameter int unsigned T_CSR_NS    = 10,
    parameter int unsigned MAX_PENDING = 8,
    parameter bit          RAS_ONLY    = 1'b0,
    localparam int unsigned ROW_W      = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             ready
);
    localparam int unsigned PWR_CYC = cyc_ceil(POWERUP_NS, CLK_NS);
    localparam int unsigned INT_CYC = cyc_floor(WINDOW_NS / ROWS, CLK_NS);
    localparam int unsigned RAS_CYC = cyc_ceil(T_RAS_NS, CLK_NS);
    localparam int unsigned RP_CYC  = cyc_ceil(T_RP_NS, CLK_NS);
    localparam int unsigned RC_CYC  = cyc_ceil(T_RC_NS, CLK_NS);
    localparam int unsigned CSR_CYC = cyc_ceil(T_CSR_NS, CLK_NS);
    localparam int unsigned PRE_CYC = max2(RP_CYC, (RC_CYC > RAS_CYC) ? RC_CYC - RAS_CYC : 1);
    localparam int unsigned PW      = $clog2(PWR_CYC + 1);
    localparam int unsigned WW      = $clog2(WARMUP_REFS + 1);

    init_e         init;
    logic [PW-1:0] pwr_cnt;
    logic [WW-1:0] warm_cnt;
    logic          run, seq_idle, seq_done, start, tick, owed;

    assign run   = (init == INIT_RUN);
    assign start = seq_idle && ((init == INIT_WARM) ||
                                (run && owed && (ref_gnt || ref_urgent)));

    // Start-up sequencing: wait, warm-up refreshes, then normal running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init     <= INIT_PWR;
            pwr_cnt  <= '0;
            warm_cnt <= '0;
        end else begin
            case (init)
                INIT_PWR: begin
                    if (pwr_cnt == PW'(PWR_CYC - 1)) init <= INIT_WARM;
                    else                             pwr_cnt <= pwr_cnt + PW'(1);
                end
                INIT_WARM: begin
                    if (seq_done) begin
                        if (warm_cnt == WW'(WARMUP_REFS - 1)) init <= INIT_RUN;
                        warm_cnt <= warm_cnt + WW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    ref_tick_gen #(.PERIOD(INT_CYC)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
    );

    ref_pending #(.LIMIT(MAX_PENDING)) pend_i (
        .clk(clk), .rst_n(rst_n), .inc(tick), .dec(start && run),
        .nonzero(owed), .urgent(ref_urgent)
    );

    ref_strobe_seq #(
        .SETUP_CYC(CSR_CYC), .ACT_CYC(RAS_CYC), .PRE_CYC(PRE_CYC),
        .ROWS(ROWS), .RAS_ONLY(RAS_ONLY)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .idle(seq_idle), .done(seq_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
    );

    assign ref_req = run && seq_idle && owed;
    assign ready   = run;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
// Property checker for the refresh scheduler, attached by bind.
// Assumes the same style and timing parameters as the bound instance.
module dram_refresh_sched_chk
    import dram_ref_pkg::*;
#(
    parameter bit          RAS_ONLY = 1'b0,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_RAS_NS = 60,
    parameter int unsigned ROW_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_gnt,
    input logic             ref_req,
    input logic             ras_n,
    input logic             cas_n,
    input logic             ready,
    input logic [ROW_W-1:0] row_addr
);
    localparam int unsigned RAS_CYC = cyc_ceil(T_RAS_NS, CLK_NS);

    logic [15:0] low_cnt;

    // Length of the current RAS-low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)      low_cnt <= '0;
        else if (!ras_n) low_cnt <= low_cnt + 16'd1;
        else             low_cnt <= '0;
    end

    // R8: RAS low for exactly the rounded-up minimum.
    a_r8_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt == 16'(RAS_CYC)));

    // R3: ready never drops once raised.
    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R10: requests only while ready and the strobes are released.
    a_r10_req_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (ras_n && cas_n && ready));

    // R10: a granted request is taken in the next cycle.
    a_r10_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> !ref_req);

    generate
        if (RAS_ONLY) begin : g_ro
            // R6: CAS stays released in the RAS-only style.
            a_r6_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
                cas_n);
            // R6: row held while RAS is low.
            a_r6_row_held: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> $stable(row_addr));
        end else begin : g_cbr
            // R4: CAS already low before RAS falls.
            a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
            // R4: CAS and RAS rise together.
            a_r4_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cas_n) |-> $rose(ras_n));
        end
    endgenerate
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .RAS_ONLY(RAS_ONLY), .CLK_NS(CLK_NS), .T_RAS_NS(T_RAS_NS), .ROW_W($clog2(ROWS))
) chk_i (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .row_addr(row_addr)
);

// File: tb/dram_refresh_sched_tb_top.sv
// Bench: one CAS-first instance and one RAS-only instance, each compared
// every clock against a behavioural model built from the requirements.
module dram_refresh_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 4096;
    localparam int WARM  = 8;
    localparam int MAXP  = 8;
    localparam int CSR   = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RASC  = (60 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int PREC  = 5;                  // max(ceil(40/10), ceil(110/10)-6)
    localparam int LEN   = CSR + RASC + PREC;
    localparam int PWR0  = 1500 / CLK_PERIOD;  // power-up cycles, instance 0
    localparam int PWR1  = 1000 / CLK_PERIOD;
    localparam int INT0  = 30;                 // refresh spacing, instance 0
    localparam int INT1  = 20;
    localparam int RUN_CYCLES = 86000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt [2];
    logic req_w [2], urg_w [2], ras_w [2], cas_w [2], we_w [2], rdy_w [2];
    logic [11:0] row_w [2];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int cyc = 0;
    bit started = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_sched #(
        .CLK_NS(CLK_PERIOD), .POWERUP_NS(1500), .WINDOW_NS(ROWS * INT0 * CLK_PERIOD),
        .RAS_ONLY(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt[0]), .ref_req(req_w[0]),
        .ref_urgent(urg_w[0]), .ras_n(ras_w[0]), .cas_n(cas_w[0]), .we_n(we_w[0]),
        .row_addr(row_w[0]), .ready(rdy_w[0])
    );

    dram_refresh_sched #(
        .CLK_NS(CLK_PERIOD), .POWERUP_NS(1000), .WINDOW_NS(ROWS * INT1 * CLK_PERIOD),
        .RAS_ONLY(1'b1)
    ) dut_ro_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt[1]), .ref_req(req_w[1]),
        .ref_urgent(urg_w[1]), .ras_n(ras_w[1]), .cas_n(cas_w[1]), .we_n(we_w[1]),
        .row_addr(row_w[1]), .ready(rdy_w[1])
    );

    // Model state per instance.
    int m_init [2];   // 0 waiting, 1 warm-up, 2 running
    int m_pcnt [2];
    int m_warm [2];
    int m_pend [2];
    int m_icnt [2];
    int m_row  [2];
    int m_pos  [2];   // -1 idle, else position inside a refresh

    function automatic int pwr_of(input int k);
        return (k == 0) ? PWR0 : PWR1;
    endfunction
    function automatic int int_of(input int k);
        return (k == 0) ? INT0 : INT1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Model update on each rising edge, using the inputs seen before it.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_init[k] = 0; m_pcnt[k] = 0; m_warm[k] = 0; m_pend[k] = 0;
                m_icnt[k] = 0; m_row[k] = 0; m_pos[k] = -1;
            end else begin
                bit idle, fin, go, tk, aend;
                idle = (m_pos[k] < 0);
                fin  = (m_pos[k] == LEN - 1);
                aend = (m_pos[k] == CSR + RASC - 1);
                go   = idle && (m_init[k] == 1 ||
                       (m_init[k] == 2 && m_pend[k] > 0 && (gnt[k] || m_pend[k] >= MAXP)));
                tk   = (m_init[k] == 2) && (m_icnt[k] == int_of(k) - 1);
                if (m_init[k] == 2) begin
                    m_icnt[k] = tk ? 0 : m_icnt[k] + 1;
                    m_pend[k] = m_pend[k] + (tk ? 1 : 0) - (go ? 1 : 0);
                    if (m_pend[k] > MAXP) m_pend[k] = MAXP;
                end
                if (m_init[k] == 0) begin
                    if (m_pcnt[k] == pwr_of(k) - 1) m_init[k] = 1;
                    else m_pcnt[k]++;
                end else if (m_init[k] == 1 && fin) begin
                    m_warm[k]++;
                    if (m_warm[k] == WARM) m_init[k] = 2;
                end
                if (k == 1 && aend) m_row[k] = (m_row[k] == ROWS - 1) ? 0 : m_row[k] + 1;
                if (fin)               m_pos[k] = -1;
                else if (m_pos[k] >= 0) m_pos[k]++;
                if (go)                m_pos[k] = 0;
            end
        end
    end

    // Directed observations.
    bit quiet_bad [2];
    int warm_seen [2];
    int rdy_cyc = -1;
    int req_cyc = -1;
    bit wrap_seen = 1'b0;
    bit urgent_start = 1'b0;
    logic p_ras [2];
    logic [11:0] p_row1 = '0;
    logic p_urg0 = 1'b0, p_gnt0 = 1'b0, p_ready0 = 1'b0;

    // Compare against the model away from the rising edge.
    always @(negedge clk) begin
        if (started && rst_n && !finished) begin
            for (int k = 0; k < 2; k++) begin
                int e_ras, e_cas;
                e_ras = (m_pos[k] >= CSR && m_pos[k] < CSR + RASC) ? 0 : 1;
                e_cas = (k == 1) ? 1 : ((m_pos[k] >= 0 && m_pos[k] < CSR + RASC) ? 0 : 1);
                chk("R8 ras_n", int'(ras_w[k]), e_ras);
                if (k == 0) chk("R4 cas_n order", int'(cas_w[k]), e_cas);
                else        chk("R6 cas_n held high", int'(cas_w[k]), e_cas);
                chk("R5 we_n high", int'(we_w[k]), 1);
                chk("R7 row_addr", int'(row_w[k]), (k == 1) ? m_row[k] : 0);
                chk("R3 ready", int'(rdy_w[k]), (m_init[k] == 2) ? 1 : 0);
                chk("R10 ref_req", int'(req_w[k]),
                    (m_init[k] == 2 && m_pos[k] < 0 && m_pend[k] > 0) ? 1 : 0);
                chk("R11 ref_urgent", int'(urg_w[k]), (m_pend[k] >= MAXP) ? 1 : 0);
                if (cyc <= pwr_of(k) && (!ras_w[k] || !cas_w[k])) quiet_bad[k] = 1'b1;
                if (p_ras[k] && !ras_w[k] && !rdy_w[k]) warm_seen[k]++;
                p_ras[k] = ras_w[k];
            end
            if (p_row1 == 12'd4095 && row_w[1] == 12'd0) wrap_seen = 1'b1;
            p_row1 = row_w[1];
            if (p_urg0 && !p_gnt0 && !cas_w[0]) urgent_start = 1'b1;
            if (!p_ready0 && rdy_w[0]) rdy_cyc = cyc;
            if (rdy_cyc >= 0 && req_cyc < 0 && req_w[0]) req_cyc = cyc;
            p_urg0 = urg_w[0];
            p_gnt0 = gnt[0];
            p_ready0 = rdy_w[0];
        end
    end

    // Stimulus and end-of-run checks.
    initial begin
        gnt[0] = 1'b0;
        gnt[1] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            quiet_bad[k] = 1'b0; warm_seen[k] = 0; p_ras[k] = 1'b1;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        for (int k = 0; k < 2; k++) begin
            chk("R1 ras_n in reset", int'(ras_w[k]), 1);
            chk("R1 cas_n in reset", int'(cas_w[k]), 1);
            chk("R1 we_n in reset", int'(we_w[k]), 1);
            chk("R1 ready in reset", int'(rdy_w[k]), 0);
            chk("R1 ref_req in reset", int'(req_w[k]), 0);
            chk("R1 ref_urgent in reset", int'(urg_w[k]), 0);
            chk("R1 row_addr in reset", int'(row_w[k]), 0);
        end
        rst_n = 1'b1;
        // Instance 0: no grant until the owed count saturates (R11).
        repeat (800) @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            gnt[0] = (i % 5 == 0);
            @(negedge clk);
        end
        gnt[0] = 1'b1;
        while (cyc < RUN_CYCLES) @(negedge clk);
        chk("R2 strobes quiet during power-up wait inst0", int'(quiet_bad[0]), 0);
        chk("R2 strobes quiet during power-up wait inst1", int'(quiet_bad[1]), 0);
        chk("R3 warm-up refresh count inst0", warm_seen[0], WARM);
        chk("R3 warm-up refresh count inst1", warm_seen[1], WARM);
        chk("R9 first request delay after ready", req_cyc - rdy_cyc, INT0);
        chk("R11 forced refresh without grant", int'(urgent_start), 1);
        chk("R7 row counter wrap 4095 to 0", int'(wrap_seen), 1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule